// File: doc/BRIEF.md
# E1 Sa6 Code-Word Detector

This block watches the Sa6 spare bit recovered from an E1 receive stream. It collects four consecutive Sa6 bits into a code word. It then sorts the word into one of five fixed patterns, or into a single class that covers every other value. A class is reported only after the same word has arrived three times in a row. The reported class sets a sticky bit in a status register. Reading the register clears it. A one-cycle interrupt pulse marks every change of the reported class.

Each arriving Sa6 bit is presented on a single-cycle strobe. The block can align its code words to submultiframe boundaries and accept updates only while multiframe alignment is held. It can also ignore the multiframe state and group the bits freely. In both cases, all updates stop while basic frame alignment is lost. Software, or a register wrapper, samples `rd_data` and pulses `rd_en` to consume the status.

Top module: `sa6_code_detector`

## Requirements
- R1: Four accepted Sa6 bits form one code word, and the first bit received becomes the most significant bit (bit 3) of the word.
- R2: Status bit positions are: bit 0 for word 1000, bit 1 for 1010, bit 2 for 1100, bit 3 for 1110, bit 4 for 1111, and bit 5 for every other 4-bit value.
- R3: A status bit is set only when the same word has completed three consecutive times. Any differing word restarts the count at one. Each further repeat sets the bit again. The bit becomes visible on the second clock edge after the strobe of the word's fourth bit.
- R4: `rd_data` always shows the status register. A clock edge with `rd_en` high clears every bit that is not being set on that same edge.
- R5: `irq` is high for exactly one cycle, in the same cycle the status bit appears, when the validated class differs from the last validated class. After reset no class counts as validated. Validating the same class again gives no pulse.
- R6: While `frm_ok` is low, no status bit is set and no interrupt is raised. A partial word and the repeat count are discarded. After alignment returns, grouping restarts at the next Sa6 bit.
- R7: With `sync_mode` high, a word starts at a bit strobed together with `smf_start`. Bits that do not belong to a word started this way are ignored. Status and interrupt update only while `mfa_ok` is high.
- R8: With `sync_mode` low, `smf_start` and `mfa_ok` have no effect, and groups of four run back to back.
- R9: A set status bit stays set until it is read. A read on the same edge as a new set leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sa6_vld | input | 1 | One-cycle strobe: a received Sa6 bit is present |
| sa6_bit | input | 1 | Value of the Sa6 bit, qualified by sa6_vld |
| smf_start | input | 1 | With sa6_vld, marks the first Sa6 bit of a submultiframe |
| frm_ok | input | 1 | Basic frame alignment held |
| mfa_ok | input | 1 | Multiframe alignment held |
| sync_mode | input | 1 | 1: words aligned to submultiframes; 0: free grouping |
| rd_en | input | 1 | Status read strobe; clears the status register |
| rd_data | output | 6 | Status register, one bit per class (see R2) |
| irq | output | 1 | One-cycle pulse on a change of validated class |

## Verification
The checker module tests several rules on every cycle:
- at most one class is set per word;
- a status bit rises only right after a completed word;
- the interrupt appears only with a status bit set, and only while the alignment inputs allowed it on the previous edge;
- a read leaves nothing but fresh sets;
- unread bits never drop.

The bench scenarios cover what a single-cycle property cannot see. It sweeps all sixteen words through the bit ordering, the class table and the three-in-a-row rule. It also covers run restarts, regrouping after lost alignment, submultiframe realignment and a read that collides with a set.

// File: rtl/sa6_det_pkg.sv
package sa6_det_pkg;
   localparam int SA6_WORD_BITS = 4;
   localparam int SA6_NUM_PAT   = 5;
   localparam int SA6_NUM_CLASS = SA6_NUM_PAT + 1;

   typedef logic [SA6_WORD_BITS-1:0] sa6_word_t;
   typedef logic [SA6_NUM_CLASS-1:0] sa6_cls_t;

   // index k of this table is status bit k; the catch-all class is the top bit
   localparam sa6_word_t SA6_PAT [SA6_NUM_PAT] = '{
      4'b1000, 4'b1010, 4'b1100, 4'b1110, 4'b1111
   };
endpackage

// File: rtl/sa6_word_assembler.sv
module sa6_word_assembler
   import sa6_det_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sa6_vld,
   input  logic      sa6_bit,
   input  logic      smf_start,
   input  logic      frm_ok,
   input  logic      sync_mode,
   output logic      word_vld,
   output sa6_word_t word
);
   localparam int CNT_W = $clog2(SA6_WORD_BITS) + 1;
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SA6_WORD_BITS - 1);

   sa6_word_t        sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   sa6_word_t        sh_nx;

   assign sh_nx = {sh_q[SA6_WORD_BITS-2:0], sa6_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         cnt_q    <= '0;
         armed_q  <= 1'b0;
         word_vld <= 1'b0;
         word     <= '0;
      end else begin
         word_vld <= 1'b0;
         if (!frm_ok) begin
            // alignment lost: drop any partial word
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else if (sa6_vld) begin
            if (sync_mode && smf_start) begin
               // submultiframe boundary: this bit opens a new word
               sh_q    <= {{(SA6_WORD_BITS-1){1'b0}}, sa6_bit};
               cnt_q   <= CNT_W'(1);
               armed_q <= 1'b1;
            end else if (armed_q || !sync_mode) begin
               sh_q <= sh_nx;
               if (cnt_q == LAST_POS) begin
                  word_vld <= 1'b1;
                  word     <= sh_nx;
                  cnt_q    <= '0;
                  armed_q  <= !sync_mode;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sa6_classifier.sv
module sa6_classifier
   import sa6_det_pkg::*;
(
   input  sa6_word_t word,
   output sa6_cls_t  cls
);
   logic [SA6_NUM_PAT-1:0] hit;

   for (genvar k = 0; k < SA6_NUM_PAT; k++) begin : g_pat
      assign hit[k] = (word == SA6_PAT[k]);
   end

   assign cls = {~|hit, hit};
endmodule

// File: rtl/sa6_run_validator.sv
module sa6_run_validator
   import sa6_det_pkg::*;
#(
   parameter int RUN_LEN = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frm_ok,
   input  logic      upd_ok,
   input  logic      word_vld,
   input  sa6_word_t word,
   input  sa6_cls_t  cls,
   output sa6_cls_t  set_vec,
   output logic      chg_ev
);
   localparam int RUN_W = $clog2(RUN_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

   sa6_word_t        last_q;
   logic             last_vld_q;
   logic [RUN_W-1:0] run_q, run_nx;
   sa6_cls_t         det_q;
   logic             same, qual;

   always_comb begin
      same   = last_vld_q && (word == last_q);
      if (!same)                run_nx = RUN_W'(1);
      else if (run_q == RUN_MAX) run_nx = run_q;
      else                      run_nx = run_q + 1'b1;
      qual    = word_vld && upd_ok && (run_nx == RUN_MAX);
      set_vec = qual ? cls : '0;
      chg_ev  = qual && (cls != det_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q     <= '0;
         last_vld_q <= 1'b0;
         run_q      <= '0;
         det_q      <= '0;
      end else begin
         if (!frm_ok) begin
            last_vld_q <= 1'b0;
            run_q      <= '0;
         end else if (word_vld) begin
            last_q     <= word;
            last_vld_q <= 1'b1;
            run_q      <= run_nx;
         end
         if (qual) det_q <= cls;
      end
   end
endmodule

// File: rtl/sa6_status_reg.sv
module sa6_status_reg
   import sa6_det_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  sa6_cls_t set_vec,
   input  logic     chg_ev,
   input  logic     rd_en,
   output sa6_cls_t status,
   output logic     irq
);
   for (genvar i = 0; i < SA6_NUM_CLASS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status[i] <= 1'b0;
         else        status[i] <= set_vec[i] | (status[i] & ~rd_en);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= chg_ev;
   end
endmodule

// File: rtl/sa6_code_detector.sv
module sa6_code_detector
   import sa6_det_pkg::*;
#(
   parameter int RUN_LEN = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sa6_vld,
   input  logic                     sa6_bit,
   input  logic                     smf_start,
   input  logic                     frm_ok,
   input  logic                     mfa_ok,
   input  logic                     sync_mode,
   input  logic                     rd_en,
   output logic [SA6_NUM_CLASS-1:0] rd_data,
   output logic                     irq
);
   if (RUN_LEN < 1) begin : g_bad_run
      $error("sa6_code_detector: RUN_LEN must be at least 1");
   end

   logic      word_vld;
   sa6_word_t word;
   sa6_cls_t  cls;
   sa6_cls_t  set_vec;
   logic      chg_ev;
   logic      upd_ok;

   assign upd_ok = frm_ok && (!sync_mode || mfa_ok);

   sa6_word_assembler u_asm (
      .clk(clk), .rst_n(rst_n), .sa6_vld(sa6_vld), .sa6_bit(sa6_bit),
      .smf_start(smf_start), .frm_ok(frm_ok), .sync_mode(sync_mode),
      .word_vld(word_vld), .word(word)
   );

   sa6_classifier u_cls (.word(word), .cls(cls));

   sa6_run_validator #(.RUN_LEN(RUN_LEN)) u_val (
      .clk(clk), .rst_n(rst_n), .frm_ok(frm_ok), .upd_ok(upd_ok),
      .word_vld(word_vld), .word(word), .cls(cls),
      .set_vec(set_vec), .chg_ev(chg_ev)
   );

   sa6_status_reg u_st (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .chg_ev(chg_ev),
      .rd_en(rd_en), .status(rd_data), .irq(irq)
   );
endmodule

// File: rtl/sa6_code_detector_chk.sv
module sa6_code_detector_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frm_ok,
   input logic       mfa_ok,
   input logic       sync_mode,
   input logic       rd_en,
   input logic [5:0] rd_data,
   input logic       irq,
   input logic [5:0] set_vec,
   input logic       word_vld
);
   p_one_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec));

   p_rise_after_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data & ~$past(rd_data)) != 6'd0) |-> $past(word_vld));

   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en) |-> ((rd_data & ~$past(set_vec)) == 6'd0));

   p_irq_has_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rd_data != 6'd0));

   p_irq_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(frm_ok));

   p_irq_mfa_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(sync_mode)) |-> $past(mfa_ok));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> ((rd_data & $past(rd_data)) == $past(rd_data)));
endmodule

bind sa6_code_detector sa6_code_detector_chk u_chk (
   .clk(clk), .rst_n(rst_n), .frm_ok(frm_ok), .mfa_ok(mfa_ok),
   .sync_mode(sync_mode), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
   .set_vec(set_vec), .word_vld(word_vld)
);

// File: tb/sa6_code_detector_bench.sv
module sa6_code_detector_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sa6_vld = 1'b0, sa6_bit = 1'b0, smf_start = 1'b0;
   logic       frm_ok = 1'b1, mfa_ok = 1'b1, sync_mode = 1'b0, rd_en = 1'b0;
   logic [5:0] rd_data;
   logic       irq;
   int         n_chk = 0, n_err = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   sa6_code_detector u_sa6_code_detector (
      .clk(clk), .rst_n(rst_n), .sa6_vld(sa6_vld), .sa6_bit(sa6_bit),
      .smf_start(smf_start), .frm_ok(frm_ok), .mfa_ok(mfa_ok),
      .sync_mode(sync_mode), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
   );

   function automatic int exp_cls(input logic [3:0] w);
      if (w == 4'b1000) return 0;
      if (w == 4'b1010) return 1;
      if (w == 4'b1100) return 2;
      if (w == 4'b1110) return 3;
      if (w == 4'b1111) return 4;
      return 5;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, input logic smf);
      @(negedge clk);
      sa6_vld = 1'b1; sa6_bit = b; smf_start = smf;
      @(negedge clk);
      sa6_vld = 1'b0; smf_start = 1'b0;
   endtask

   // ends at the negedge while the completed word is pending
   task automatic send_word(input logic [3:0] w, input logic smf);
      for (int i = 3; i >= 0; i--) send_bit(w[i], smf && (i == 3));
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic do_read(output logic [5:0] got);
      got = rd_data;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [5:0] got;
      int det;
      det = -1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset rd_data", rd_data, 6'd0);
      chk("reset irq", irq, 1'b0);

      // R1 R2 R3 R5: sweep every word in free grouping mode
      for (int w = 0; w < 16; w++) begin
         int c;
         c = exp_cls(4'(w));
         do_read(got);
         chk("R4 clear after read", rd_data, 6'd0);
         send_word(4'(w), 1'b0); settle();
         chk("R3 first copy no status", rd_data, 6'd0);
         send_word(4'(w), 1'b0); settle();
         chk("R3 second copy no status", rd_data, 6'd0);
         send_word(4'(w), 1'b0); settle();
         chk("R1 R2 R3 third copy class bit", rd_data, 6'd1 << c);
         chk("R5 irq on class change", irq, (c != det) ? 1'b1 : 1'b0);
         det = c;
         send_word(4'(w), 1'b0); settle();
         chk("R5 repeat no irq", irq, 1'b0);
         do_read(got);
         chk("R4 read returns status", got, 6'd1 << c);
      end

      // R3: a differing word restarts the run
      do_read(got);
      send_word(4'b1010, 1'b0); send_word(4'b1010, 1'b0);
      send_word(4'b1000, 1'b0);
      send_word(4'b1010, 1'b0); send_word(4'b1010, 1'b0); settle();
      chk("R3 broken run no status", rd_data, 6'd0);
      send_word(4'b1010, 1'b0); settle();
      chk("R3 restarted run sets", rd_data, 6'b000010);
      chk("R5 irq 1111 to 1010", irq, 1'b1);
      do_read(got);

      // R6: no updates while frame alignment lost
      frm_ok = 1'b0;
      repeat (3) send_word(4'b1000, 1'b0);
      settle();
      chk("R6 no status while unaligned", rd_data, 6'd0);
      chk("R6 no irq while unaligned", irq, 1'b0);
      frm_ok = 1'b1;
      send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
      @(negedge clk); frm_ok = 1'b0;
      @(negedge clk); frm_ok = 1'b1;
      send_word(4'b1000, 1'b0); send_word(4'b1000, 1'b0); settle();
      chk("R6 regroup two copies no status", rd_data, 6'd0);
      send_word(4'b1000, 1'b0); settle();
      chk("R6 regroup after realign", rd_data, 6'b000001);
      chk("R6 irq after realign", irq, 1'b1);
      do_read(got);

      // R9: read colliding with a set keeps the bit
      send_word(4'b1000, 1'b0);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R9 set wins over read", rd_data, 6'b000001);
      send_word(4'b1010, 1'b0); settle();
      chk("R9 bit held without read", rd_data, 6'b000001);
      do_read(got);
      chk("R4 cleared after read", rd_data, 6'd0);

      // R7: submultiframe aligned mode
      sync_mode = 1'b1; mfa_ok = 1'b0;
      repeat (3) send_word(4'b1100, 1'b1);
      settle();
      chk("R7 no status without mfa", rd_data, 6'd0);
      chk("R7 no irq without mfa", irq, 1'b0);
      send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
      mfa_ok = 1'b1;
      send_word(4'b1100, 1'b1); settle();
      chk("R7 stray bits ignored, mfa regained", rd_data, 6'b000100);
      chk("R7 irq with mfa", irq, 1'b1);
      do_read(got);
      send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b0);
      send_word(4'b1110, 1'b1); send_word(4'b1110, 1'b1);
      send_word(4'b1110, 1'b1); settle();
      chk("R7 boundary realigns word", rd_data, 6'b001000);
      do_read(got);

      // R8: free grouping ignores mfa_ok and smf_start
      sync_mode = 1'b0; mfa_ok = 1'b0;
      send_word(4'b1111, 1'b1); send_word(4'b1111, 1'b0);
      send_word(4'b1111, 1'b1); settle();
      chk("R8 free mode ignores mfa and boundary", rd_data, 6'b010000);
      chk("R8 irq in free mode", irq, 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule